// File: doc/BRIEF.md
# Far-End Alarm Code Receiver

This block listens to the far-end alarm and control channel of a DS3 receive path. An upstream framer hands it one channel bit per frame, marked by a one-cycle strobe. The block looks for the 8-bit alignment pattern. It captures the 6-bit code word that follows each pattern and keeps the last ten captured words in a history. From that history it decides when a code word is steady enough to count as validated, and when a validated word has been displaced.

The two decisions are visible in two ways. The first is an 8-bit control/status register with interrupt enables, clear-on-read event flags and a read-only valid flag. The second is a single interrupt line. The most recently validated code word is also driven on its own 6-bit output.

The message finder has two states:
- HUNT: compares the sliding 8-bit window with the pattern on each strobed bit. A match moves it to CAPTURE.
- CAPTURE: shifts in code bits. After the sixth bit it goes back to HUNT with an empty window.

The voter has two states:
- OPEN: no code is validated. A qualifying match moves it to HELD, which is the validate transition.
- HELD: a code is validated. Enough differing words move it back to OPEN, which is the remove transition.

Top module: `feac_rx`

## Requirements
- R1: Only cycles with `bit_vld` high take a bit. The alignment pattern is 01111110, with the first received bit leftmost.
- R2: The 6 strobed bits right after a pattern form the code word, with the first bit as MSB. These bits are not searched for a pattern. After the sixth bit the search restarts with an empty window.
- R3: In OPEN, a captured word equal to at least 8 of the last 10 history entries is validated. Entries that are empty since reset never match. Validation sets register bit 4, loads `code_out` and sets status bit 0.
- R4: In HELD, the code is removed once at least 3 of the last 10 valid entries differ from the validated word. Removal clears bit 4 and sets status bit 2. `code_out` keeps the last validated word.
- R5: While a code is validated, further matching messages raise no new validation event.
- R6: Register layout: bit 3 is the removal enable, bit 1 is the validation enable, bit 4 is the valid flag, bits 2 and 0 are the status flags, and bits 7:5 read 0. A write changes only bits 3 and 1. For example, writing xxxx1010 enables both interrupts.
- R7: A `reg_rd` pulse clears both status bits. If an event arrives in the same cycle, its status bit stays set.
- R8: A status bit is set whether or not its enable is set. `irq` is high when any status bit and its enable are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Serial channel bit |
| bit_vld | input | 1 | Strobe: `bit_in` is valid this cycle |
| reg_rd | input | 1 | Register read pulse (clears status) |
| reg_wr | input | 1 | Register write pulse |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| code_out | output | 6 | Last validated code word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit pattern, a 6-bit code, a 10-entry history, a validation threshold of 8 and a removal threshold of 3. With these values the seventh and eighth equal messages fall on either side of the validation edge. The third differing message triggers removal. A run after removal shows that stale differing entries keep a code at 7 of 10 without validating it. A removal event is timed to land in the same cycle as a register read, which exercises the event-wins rule.

// File: rtl/feac_rx_pkg.sv
package feac_rx_pkg;
    typedef enum logic {FR_HUNT, FR_CAPTURE} frm_state_t;
    typedef enum logic {VT_OPEN, VT_HELD}    vote_state_t;

    localparam int REG_VAL_ST  = 0;
    localparam int REG_VAL_EN  = 1;
    localparam int REG_REM_ST  = 2;
    localparam int REG_REM_EN  = 3;
    localparam int REG_VALID   = 4;
endpackage

// File: rtl/feac_rx_deframer.sv
module feac_rx_deframer
    import feac_rx_pkg::*;
#(
    parameter int          PAT_W   = 8,
    parameter logic [7:0]  PATTERN = 8'h7E,
    parameter int          CODE_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    output logic              code_vld,
    output logic [CODE_W-1:0] code
);
    localparam int CNT_W = $clog2(CODE_W);

    frm_state_t         state, nxt;
    logic [PAT_W-1:0]   win;
    logic [PAT_W-1:0]   win_next;
    logic [CODE_W-1:0]  shreg;
    logic [CNT_W-1:0]   cnt;
    logic               hit, last;

    assign win_next = {win[PAT_W-2:0], bit_in};
    assign hit      = bit_vld && (win_next == PATTERN[PAT_W-1:0]);
    assign last     = bit_vld && (cnt == CNT_W'(CODE_W-1));

    always_comb begin
        nxt = state;
        unique case (state)
            FR_HUNT:    if (hit)  nxt = FR_CAPTURE;
            FR_CAPTURE: if (last) nxt = FR_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FR_HUNT;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win      <= '0;
            shreg    <= '0;
            cnt      <= '0;
            code     <= '0;
            code_vld <= 1'b0;
        end else begin
            code_vld <= 1'b0;
            if (bit_vld) begin
                unique case (state)
                    FR_HUNT: begin
                        win <= hit ? '0 : win_next;
                        cnt <= '0;
                    end
                    FR_CAPTURE: begin
                        shreg <= {shreg[CODE_W-2:0], bit_in};
                        cnt   <= cnt + 1'b1;
                        if (last) begin
                            code     <= {shreg[CODE_W-2:0], bit_in};
                            code_vld <= 1'b1;
                            win      <= '0;
                        end
                    end
                endcase
            end
        end
    end

    // R2: a captured word always follows a strobed bit
    p_code_after_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |-> $past(bit_vld));
    // R1: leaving the hunt requires a strobed bit
    p_hunt_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_CAPTURE) && $past(state == FR_HUNT) |-> $past(bit_vld));
endmodule

// File: rtl/feac_rx_vote.sv
module feac_rx_vote
    import feac_rx_pkg::*;
#(
    parameter int CODE_W     = 6,
    parameter int DEPTH      = 10,
    parameter int VALID_CNT  = 8,
    parameter int REMOVE_CNT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_vld,
    input  logic [CODE_W-1:0] code,
    output logic              locked,
    output logic [CODE_W-1:0] locked_code,
    output logic              val_evt,
    output logic              rem_evt
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    vote_state_t        state, nxt;
    logic [CODE_W-1:0]  hist_code [DEPTH];
    logic               hist_used [DEPTH];
    logic [CODE_W-1:0]  nc [DEPTH];
    logic               nu [DEPTH];
    logic [CNT_W-1:0]   match_cnt, diff_cnt;

    always_comb begin
        nc[0] = code;
        nu[0] = 1'b1;
        for (int i = 1; i < DEPTH; i++) begin
            nc[i] = hist_code[i-1];
            nu[i] = hist_used[i-1];
        end
        match_cnt = '0;
        diff_cnt  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            match_cnt = match_cnt + CNT_W'(nu[i] && (nc[i] == code));
            diff_cnt  = diff_cnt  + CNT_W'(nu[i] && (nc[i] != locked_code));
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            VT_OPEN: if (code_vld && match_cnt >= CNT_W'(VALID_CNT))  nxt = VT_HELD;
            VT_HELD: if (code_vld && diff_cnt  >= CNT_W'(REMOVE_CNT)) nxt = VT_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= VT_OPEN;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                hist_code[i] <= '0;
                hist_used[i] <= 1'b0;
            end
            locked_code <= '0;
            val_evt     <= 1'b0;
            rem_evt     <= 1'b0;
        end else begin
            val_evt <= (state == VT_OPEN) && (nxt == VT_HELD);
            rem_evt <= (state == VT_HELD) && (nxt == VT_OPEN);
            if ((state == VT_OPEN) && (nxt == VT_HELD)) locked_code <= code;
            if (code_vld) begin
                for (int i = 0; i < DEPTH; i++) begin
                    hist_code[i] <= nc[i];
                    hist_used[i] <= nu[i];
                end
            end
        end
    end

    assign locked = (state == VT_HELD);

    // R3: validation only on a captured word
    p_rise_on_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(code_vld));
    // R4: removal only on a captured word
    p_fall_on_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(code_vld));
    // R5: a validation event only marks a fresh lock
    p_no_revalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        val_evt |-> $rose(locked));
    // R4: a removal event only marks a fresh unlock
    p_rem_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rem_evt |-> $fell(locked));
endmodule

// File: rtl/feac_rx_regs.sv
module feac_rx_regs
    import feac_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       val_evt,
    input  logic       rem_evt,
    input  logic       locked,
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq
);
    logic val_en, rem_en, val_st, rem_st;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_en <= 1'b0;
            rem_en <= 1'b0;
            val_st <= 1'b0;
            rem_st <= 1'b0;
        end else begin
            if (wr) begin
                val_en <= wdata[REG_VAL_EN];
                rem_en <= wdata[REG_REM_EN];
            end
            if (val_evt)  val_st <= 1'b1;
            else if (rd)  val_st <= 1'b0;
            if (rem_evt)  rem_st <= 1'b1;
            else if (rd)  rem_st <= 1'b0;
        end
    end

    always_comb begin
        rdata             = '0;
        rdata[REG_VAL_ST] = val_st;
        rdata[REG_VAL_EN] = val_en;
        rdata[REG_REM_ST] = rem_st;
        rdata[REG_REM_EN] = rem_en;
        rdata[REG_VALID]  = locked;
    end

    assign irq = (val_st && val_en) || (rem_st && rem_en);

    // R7: an event beats a same-cycle read
    p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        val_evt |=> val_st);
    // R7: a read with no event clears removal status
    p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !rem_evt |=> !rem_st);
    // R6: enables move only on a write
    p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable({val_en, rem_en}));
    // R8: set status is not lost without a read
    p_st_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rem_st && !rd |=> rem_st);
endmodule

// File: rtl/feac_rx.sv
module feac_rx #(
    parameter int         PAT_W      = 8,
    parameter logic [7:0] PATTERN    = 8'h7E,
    parameter int         CODE_W     = 6,
    parameter int         DEPTH      = 10,
    parameter int         VALID_CNT  = 8,
    parameter int         REMOVE_CNT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_vld,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [CODE_W-1:0] code_out,
    output logic              irq
);
    logic              code_vld;
    logic [CODE_W-1:0] code;
    logic              locked, val_evt, rem_evt;

    feac_rx_deframer #(.PAT_W(PAT_W), .PATTERN(PATTERN), .CODE_W(CODE_W)) u_frm (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .code_vld(code_vld), .code(code));

    feac_rx_vote #(.CODE_W(CODE_W), .DEPTH(DEPTH), .VALID_CNT(VALID_CNT),
                   .REMOVE_CNT(REMOVE_CNT)) u_vote (
        .clk(clk), .rst_n(rst_n), .code_vld(code_vld), .code(code),
        .locked(locked), .locked_code(code_out),
        .val_evt(val_evt), .rem_evt(rem_evt));

    feac_rx_regs u_regs (
        .clk(clk), .rst_n(rst_n), .val_evt(val_evt), .rem_evt(rem_evt),
        .locked(locked), .rd(reg_rd), .wr(reg_wr), .wdata(reg_wdata),
        .rdata(reg_rdata), .irq(irq));
endmodule

// File: tb/tb_feac_rx.sv
`timescale 1ns/1ps
module tb_feac_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0, bit_vld = 1'b0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [5:0] code_out;
    logic       irq;
    int         errors = 0, checks = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    feac_rx dut (.clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .code_out(code_out), .irq(irq));

    // {code, expected valid flag after this message}
    localparam logic [6:0] VEC [15] = '{
        {6'h2C,1'b0},{6'h2C,1'b0},{6'h2C,1'b0},{6'h2C,1'b0},{6'h2C,1'b0},
        {6'h2C,1'b0},{6'h2C,1'b0},{6'h2C,1'b1},{6'h2C,1'b1},{6'h2C,1'b1},
        {6'h13,1'b1},{6'h13,1'b1},{6'h05,1'b0},{6'h2C,1'b0},{6'h2C,1'b0}};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input bit race);
        @(negedge clk); bit_in = b; bit_vld = 1'b1;
        @(negedge clk); bit_vld = 1'b0; bit_in = ~b;
        @(negedge clk); if (race) reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic send_msg(input logic [5:0] c, input bit race);
        logic [5:0]  junk = 6'b110111;
        logic [7:0]  pat  = 8'b01111110;
        for (int i = 5; i >= 0; i--) send_bit(junk[i], 1'b0);
        for (int i = 7; i >= 0; i--) send_bit(pat[i], 1'b0);
        for (int i = 5; i >= 0; i--) send_bit(c[i], race && (i == 0));
        @(negedge clk);
    endtask

    task automatic pulse_rd();
        @(negedge clk); reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(reg_rdata == 8'h00, "R6 reset register", reg_rdata, 8'h00);
        check(irq == 1'b0, "R8 reset irq", irq, 0);
        check(code_out == 6'h00, "R3 reset code_out", code_out, 0);

        // table walk: R1/R2 framing, R3 validation, R4 removal
        for (int k = 0; k < 15; k++) begin
            send_msg(VEC[k][6:1], 1'b0);
            check(reg_rdata[4] == VEC[k][0], $sformatf("R3/R4 valid flag msg %0d", k),
                  reg_rdata[4], VEC[k][0]);
        end

        check(reg_rdata[0] == 1'b1, "R8 val status set while disabled", reg_rdata[0], 1);
        check(reg_rdata[2] == 1'b1, "R8 rem status set while disabled", reg_rdata[2], 1);
        check(irq == 1'b0, "R8 irq masked", irq, 0);
        check(code_out == 6'h2C, "R2 code bit order / R4 code kept", code_out, 6'h2C);

        @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'hFA;
        @(negedge clk); reg_wr = 1'b0;
        @(negedge clk);
        check(reg_rdata == 8'h0F, "R6 write xxxx1010 layout", reg_rdata, 8'h0F);
        check(irq == 1'b1, "R8 irq enabled", irq, 1);

        pulse_rd();
        check(reg_rdata == 8'h0A, "R7 read clears status", reg_rdata, 8'h0A);
        check(irq == 1'b0, "R7 irq after read", irq, 0);

        for (int k = 0; k < 7; k++) send_msg(6'h3F, 1'b0);
        check(reg_rdata[4] == 1'b0, "R3 seven of ten not enough", reg_rdata[4], 0);
        send_msg(6'h3F, 1'b0);
        check(reg_rdata[4] == 1'b1, "R3 eighth message validates", reg_rdata[4], 1);
        check(irq == 1'b1, "R8 irq on validation", irq, 1);
        check(code_out == 6'h3F, "R3 code_out loaded", code_out, 6'h3F);

        pulse_rd();
        send_msg(6'h3F, 1'b0);
        send_msg(6'h3F, 1'b0);
        check(reg_rdata[0] == 1'b0, "R5 no re-validation", reg_rdata[0], 0);
        check(irq == 1'b0, "R5 irq stays low", irq, 0);

        send_msg(6'h21, 1'b0);
        send_msg(6'h21, 1'b0);
        check(reg_rdata[4] == 1'b1, "R4 two differing keep lock", reg_rdata[4], 1);
        send_msg(6'h21, 1'b1);
        check(reg_rdata[4] == 1'b0, "R4 third differing removes", reg_rdata[4], 0);
        check(reg_rdata[2] == 1'b1, "R7 event wins over read", reg_rdata[2], 1);
        check(irq == 1'b1, "R8 irq on removal", irq, 1);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule